// File: doc/BRIEF.md
# Flowlet Next-Hop Selector

This block picks an output next hop for every packet in a line-rate pipeline, one packet per clock cycle. Each packet carries a source port, a destination port and an arrival timestamp. Two CRC16 hashes are computed from these fields. The first hash maps the port pair onto a flowlet slot. The second hash mixes the ports with the timestamp and yields a candidate hop.

Each slot keeps two pieces of state: the time its most recent packet arrived, and the hop it is currently bound to. A packet that arrives after the slot has been quiet for longer than a threshold starts a new flowlet. Such a packet rebinds the slot to the candidate hop. Any other packet follows the hop the slot already holds. As a result, traffic is balanced across hops flowlet by flowlet, and packets that arrive close together stay on the same path.

The work is split across a hash stage, a last-time stage and a hop stage. Each table's read and its write are kept inside a single stage. Because of this, a packet always sees the update made by the packet in front of it, even when the two arrive on consecutive cycles.

Top module: `flowlet_hop_sel`

## Requirements
- R1: The candidate hop is computed as CRC16(poly 0x1021, initial value 0x1D0F, no reflection, no final XOR) over the 64-bit word {src_port, dst_port, time}, fed most significant bit first, then taken modulo NUM_HOPS. Every out_hop value is below NUM_HOPS.
- R2: The slot index is computed as CRC16(same polynomial, initial value 0xFFFF) over the 32-bit word {src_port, dst_port}, fed most significant bit first, then taken modulo NUM_SLOTS.
- R3: The gap is time minus the slot's stored last time, computed modulo 2^TIME_W. When the gap is strictly greater than THRESH, the slot's saved hop is replaced by the candidate hop, and out_hop is the candidate hop.
- R4: When the gap is at most THRESH (a gap exactly equal to THRESH included), out_hop is the slot's saved hop and the saved hop is left unchanged.
- R5: Every accepted packet writes its own time into its slot's last-time entry, whatever the outcome of the gap test.
- R6: Reset clears both tables to zero and holds out_vld low. For the first packet into a slot, the gap is therefore measured from time 0, and the saved hop is 0.
- R7: One packet is accepted per cycle. Each result appears on out_vld/out_hop exactly 3 clock edges after the edge that samples the packet, and results leave in arrival order. A packet that directly follows another packet to the same slot sees that packet's updates.
- R8: While in_vld is low, the port and time inputs are ignored: neither table changes and no output is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Packet present this cycle |
| in_sport | input | PORT_W | Source port |
| in_dport | input | PORT_W | Destination port |
| in_time | input | TIME_W | Arrival timestamp |
| out_vld | output | 1 | Result present |
| out_hop | output | HOP_W | Chosen next hop |

## Verification
Two things can land in the same cycle. One is a slot-table update by one packet; the other is the read of that same slot by the packet right behind it. This case is provoked by bursts of one flow on consecutive cycles. In those bursts, gaps fall both below and above the threshold, so the later packet's result depends on whether the earlier packet's last-time and hop writes are visible. A scoreboard model updates its slot state in strict packet order, and every output hop is compared against it. The same comparison covers the timestamp wrap, the equal-to-threshold boundary, and bursts of ignored garbage sent with in_vld low.

// File: rtl/flh_pkg.sv
package flh_pkg;
   localparam logic [15:0] CRC_POLY  = 16'h1021;
   localparam logic [15:0] SLOT_SEED = 16'hFFFF;
   localparam logic [15:0] HOP_SEED  = 16'h1D0F;

   // one serial CRC16 step, data bit enters at the top
   function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
      logic fb;
      logic [15:0] n;
      fb = c[15] ^ b;
      n  = {c[14:0], 1'b0};
      if (fb) n = n ^ CRC_POLY;
      return n;
   endfunction
endpackage

// File: rtl/flh_hash.sv
module flh_hash #(
   parameter int          IN_W  = 32,
   parameter logic [15:0] SEED  = 16'hFFFF,
   parameter int          MOD   = 16,
   localparam int         OUT_W = (MOD > 1) ? $clog2(MOD) : 1
) (
   input  logic [IN_W-1:0]  data,
   output logic [OUT_W-1:0] idx
);
   import flh_pkg::*;

   localparam bit IS_POW2 = ((MOD & (MOD - 1)) == 0);

   if (MOD < 2 || MOD > 65536) begin : g_bad_mod
      $error("flh_hash: MOD out of range");
   end
   if (IN_W < 1) begin : g_bad_w
      $error("flh_hash: IN_W must be positive");
   end

   logic [15:0] crc;

   always_comb begin
      crc = SEED;
      for (int i = IN_W - 1; i >= 0; i--) crc = crc16_step(crc, data[i]);
   end

   if (IS_POW2) begin : g_mask
      assign idx = crc[OUT_W-1:0];
   end else begin : g_mod
      logic [16:0] rem;
      assign rem = {1'b0, crc} % 17'(MOD);
      assign idx = rem[OUT_W-1:0];
   end
endmodule

// File: rtl/flh_gap_stage.sv
module flh_gap_stage #(
   parameter int NUM_SLOTS = 256,
   parameter int TIME_W    = 32,
   parameter int HOP_W     = 4,
   parameter int THRESH    = 5,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vld_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic [TIME_W-1:0] time_i,
   input  logic [HOP_W-1:0]  hop_i,
   output logic              vld_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic [HOP_W-1:0]  hop_o,
   output logic              gap_o
);
   if (THRESH < 0) begin : g_bad_thr
      $error("flh_gap_stage: THRESH must be non-negative");
   end

   logic [TIME_W-1:0] last_tab [NUM_SLOTS];
   logic [TIME_W-1:0] last_rd;
   logic [TIME_W-1:0] elapsed;
   logic              gap_hit;

   // read and write of the slot stay in this one stage
   always_comb begin
      last_rd = last_tab[slot_i];
      elapsed = time_i - last_rd;
      gap_hit = elapsed > TIME_W'(THRESH);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < NUM_SLOTS; s++) last_tab[s] <= '0;
         vld_o  <= 1'b0;
         slot_o <= '0;
         hop_o  <= '0;
         gap_o  <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            last_tab[slot_i] <= time_i;
            slot_o           <= slot_i;
            hop_o            <= hop_i;
            gap_o            <= gap_hit;
         end
      end
   end

   AST_LAST_TIME_STORED: assert property (@(posedge clk) disable iff (rst)
      vld_i |=> last_tab[$past(slot_i)] == $past(time_i)); // R5
   AST_IDLE_KEEPS_TIME: assert property (@(posedge clk) disable iff (rst)
      !vld_i |=> last_tab[$past(slot_i)] == $past(last_tab[slot_i])); // R8
endmodule

// File: rtl/flh_hop_stage.sv
module flh_hop_stage #(
   parameter int NUM_SLOTS = 256,
   parameter int HOP_W     = 4,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vld_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic [HOP_W-1:0]  hop_i,
   input  logic              gap_i,
   output logic              vld_o,
   output logic [HOP_W-1:0]  hop_o
);
   logic [HOP_W-1:0] saved_tab [NUM_SLOTS];
   logic [HOP_W-1:0] saved_rd;
   logic [HOP_W-1:0] pick;

   always_comb begin
      saved_rd = saved_tab[slot_i];
      pick     = gap_i ? hop_i : saved_rd;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < NUM_SLOTS; s++) saved_tab[s] <= '0;
         vld_o <= 1'b0;
         hop_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            hop_o <= pick;
            if (gap_i) saved_tab[slot_i] <= hop_i;
         end
      end
   end

   AST_NEW_FLOWLET_REBINDS: assert property (@(posedge clk) disable iff (rst)
      (vld_i && gap_i) |=> saved_tab[$past(slot_i)] == $past(hop_i)); // R3
   AST_SAME_FLOWLET_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (vld_i && !gap_i) |=> (saved_tab[$past(slot_i)] == $past(saved_tab[slot_i]))
                            && (hop_o == $past(saved_tab[slot_i]))); // R4
endmodule

// File: rtl/flowlet_hop_sel.sv
module flowlet_hop_sel #(
   parameter int  PORT_W    = 16,
   parameter int  TIME_W    = 32,
   parameter int  NUM_SLOTS = 256,
   parameter int  NUM_HOPS  = 10,
   parameter int  THRESH    = 5,
   localparam int HOP_W     = $clog2(NUM_HOPS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [PORT_W-1:0] in_sport,
   input  logic [PORT_W-1:0] in_dport,
   input  logic [TIME_W-1:0] in_time,
   output logic              out_vld,
   output logic [HOP_W-1:0]  out_hop
);
   import flh_pkg::*;

   localparam int SLOT_W = $clog2(NUM_SLOTS);
   localparam int KEY_W  = 2 * PORT_W;

   if (NUM_HOPS < 2) begin : g_bad_hops
      $error("flowlet_hop_sel: NUM_HOPS must be at least 2");
   end
   if (NUM_SLOTS < 2 || NUM_SLOTS > 4096) begin : g_bad_slots
      $error("flowlet_hop_sel: NUM_SLOTS out of range");
   end

   // stage 1: hashes
   logic [SLOT_W-1:0] slot_c;
   logic [HOP_W-1:0]  hop_c;

   flh_hash #(.IN_W(KEY_W), .SEED(SLOT_SEED), .MOD(NUM_SLOTS)) u_slot_hash (
      .data ({in_sport, in_dport}),
      .idx  (slot_c)
   );
   flh_hash #(.IN_W(KEY_W + TIME_W), .SEED(HOP_SEED), .MOD(NUM_HOPS)) u_hop_hash (
      .data ({in_sport, in_dport, in_time}),
      .idx  (hop_c)
   );

   logic              s1_vld;
   logic [SLOT_W-1:0] s1_slot;
   logic [HOP_W-1:0]  s1_hop;
   logic [TIME_W-1:0] s1_time;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld  <= 1'b0;
         s1_slot <= '0;
         s1_hop  <= '0;
         s1_time <= '0;
      end else begin
         s1_vld <= in_vld;
         if (in_vld) begin
            s1_slot <= slot_c;
            s1_hop  <= hop_c;
            s1_time <= in_time;
         end
      end
   end

   // stage 2: last-time table
   logic              s2_vld;
   logic [SLOT_W-1:0] s2_slot;
   logic [HOP_W-1:0]  s2_hop;
   logic              s2_gap;

   flh_gap_stage #(.NUM_SLOTS(NUM_SLOTS), .TIME_W(TIME_W), .HOP_W(HOP_W),
                   .THRESH(THRESH)) u_gap (
      .clk    (clk),
      .rst    (rst),
      .vld_i  (s1_vld),
      .slot_i (s1_slot),
      .time_i (s1_time),
      .hop_i  (s1_hop),
      .vld_o  (s2_vld),
      .slot_o (s2_slot),
      .hop_o  (s2_hop),
      .gap_o  (s2_gap)
   );

   // stage 3: saved-hop table
   flh_hop_stage #(.NUM_SLOTS(NUM_SLOTS), .HOP_W(HOP_W)) u_hop (
      .clk    (clk),
      .rst    (rst),
      .vld_i  (s2_vld),
      .slot_i (s2_slot),
      .hop_i  (s2_hop),
      .gap_i  (s2_gap),
      .vld_o  (out_vld),
      .hop_o  (out_hop)
   );

   // cycles since reset, used only to bound the latency check
   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (rst) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3) |-> (out_vld == $past(in_vld, 3))); // R7
   AST_HOP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (32'(out_hop) < NUM_HOPS)); // R1
   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> !out_vld); // R6
endmodule

// File: tb/sim_flowlet_hop_sel.sv
module sim_flowlet_hop_sel;
   localparam int PORT_W = 16, TIME_W = 32, NSLOT = 256, NHOP = 10, THR = 5;
   localparam int HOP_W = $clog2(NHOP);

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_vld = 1'b0;
   logic [PORT_W-1:0] in_sport = '0, in_dport = '0;
   logic [TIME_W-1:0] in_time = '0;
   logic              out_vld;
   logic [HOP_W-1:0]  out_hop;

   always #5 clk = ~clk;

   flowlet_hop_sel #(.PORT_W(PORT_W), .TIME_W(TIME_W), .NUM_SLOTS(NSLOT),
                     .NUM_HOPS(NHOP), .THRESH(THR)) u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_sport(in_sport),
      .in_dport(in_dport), .in_time(in_time), .out_vld(out_vld), .out_hop(out_hop));

   int checks = 0, fails = 0;
   int    exp_q[$];
   string tag_q[$];
   time   t_q[$];

   // model state
   logic [TIME_W-1:0] m_last [NSLOT];
   int                m_saved [NSLOT];

   function automatic logic [15:0] ref_crc(input logic [63:0] w, input int nbits,
                                           input logic [15:0] init);
      logic [15:0] r = init;
      for (int k = nbits - 1; k >= 0; k--) begin
         if (r[15] != w[k]) r = (r << 1) ^ 16'h1021;
         else               r = r << 1;
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input int sp, input int dp, input logic [TIME_W-1:0] t,
                       input string tag);
      int slot, nh, e;
      @(posedge clk); #1;
      in_vld = 1'b1; in_sport = PORT_W'(sp); in_dport = PORT_W'(dp); in_time = t;
      slot = int'(ref_crc({32'd0, in_sport, in_dport}, 32, 16'hFFFF)) % NSLOT; // R2
      nh   = int'(ref_crc({in_sport, in_dport, t}, 64, 16'h1D0F)) % NHOP;      // R1
      if ((t - m_last[slot]) > TIME_W'(THR)) begin m_saved[slot] = nh; e = nh; end // R3
      else e = m_saved[slot];                                                    // R4
      m_last[slot] = t;                                                          // R5
      exp_q.push_back(e); tag_q.push_back(tag); t_q.push_back($time);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         in_vld = 1'b0;
         in_sport = PORT_W'($urandom); in_dport = PORT_W'($urandom); in_time = $urandom;
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst && out_vld) begin
         if (exp_q.size() == 0) check(1'b0, "R7 unexpected output", int'(out_hop), -1);
         else begin
            int e; string tg; time t0;
            e = exp_q.pop_front(); tg = tag_q.pop_front(); t0 = t_q.pop_front();
            check(int'(out_hop) == e, tg, int'(out_hop), e);
            check(($time - t0) == 34, "R7 latency", int'($time - t0), 34);
         end
      end
   end

   initial begin
      for (int s = 0; s < NSLOT; s++) begin m_last[s] = '0; m_saved[s] = 0; end
      repeat (4) @(posedge clk);
      #1 check(out_vld == 1'b0, "R6 out_vld in reset", int'(out_vld), 0);
      rst = 1'b0;
      idle(2);
      check(out_vld == 1'b0, "R6 out_vld after reset", int'(out_vld), 0);

      send(1000, 80, 3,  "R6 first packet, zero tables");
      send(1000, 80, 8,  "R4 gap equal to threshold");
      idle(3);
      send(1000, 80, 14, "R3 gap above threshold");
      send(1000, 80, 15, "R7 back-to-back same slot");
      send(1000, 80, 25, "R7 back-to-back rebind");
      send(1000, 80, 26, "R7 back-to-back after rebind");
      idle(6);
      send(1000, 80, 31, "R8 garbage while idle ignored");
      send(1000, 80, 40, "R3 new flowlet");
      send(4242, 443, 32'hFFFF_FFFE, "R3 first touch of slot");
      send(4242, 443, 32'd3, "R4 gap across time wrap");
      send(4242, 443, 32'd10, "R3 gap above threshold after wrap");
      idle(2);
      begin
         logic [TIME_W-1:0] tnow = 32'd100;
         for (int n = 0; n < 300; n++) begin
            int f = $urandom_range(0, 5);
            tnow = tnow + $urandom_range(0, 4);
            send(2000 + f, 53 + f, tnow, "R2 mixed flows");
            if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 3));
         end
      end
      idle(8);
      check(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end
endmodule